// File: doc/BRIEF.md
# Frequency-Bin Coefficient Multiplier Bank

This block sits between a parallel forward transform and its inverse in a frequency-domain equalizer. Each clock it accepts one complex bin per lane, with a valid flag and a frame-start flag. Each bin is multiplied by a stored complex coefficient, and the product is returned at the original sample width. A transform frame of `LANES*SLOTS` points arrives over `SLOTS` consecutive valid cycles, so each lane's multiplier is time-shared across `SLOTS` bins. Each lane therefore steps through its own small set of coefficients in step with the order in which the transform emits bins.

The coefficients are the frequency response of the equalizing filter. They are computed outside the chip and written through a one-word-per-cycle port before streaming starts. The port refuses writes while any bin is entering or travelling through the bank, so a live frame never sees a half-updated coefficient set. Results leave a fixed number of cycles after the bins enter. The full-precision product is scaled back by the coefficient's fractional bits, rounded half up and clamped to the sample range.

Top module: `fbin_coef_bank`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and every stored coefficient is zero, so a frame streamed before any write produces all-zero outputs.
- R2: `out_valid` equals `in_valid` delayed by exactly three clock cycles, with no other source of output validity.
- R3: For each lane, the real output is round(dr*cr - di*ci) and the imaginary output is round(dr*ci + di*cr), where d is the bin and c is the coefficient. Both are signed two's complement, and c carries FRAC (default 7) fractional bits.
- R4: Rounding adds 2^(FRAC-1) to the full-precision result and then shifts arithmetically right by FRAC bits. Exact halves therefore go toward plus infinity: +0.5 gives 1 and -0.5 gives 0.
- R5: A rounded result above 2^(DW-1)-1 is output as 2^(DW-1)-1, and one below -2^(DW-1) is output as -2^(DW-1) (2047 and -2048 by default).
- R6: The coefficient slot used on a valid cycle is 0 when `in_sof` is high. Otherwise it is the previous valid cycle's slot plus one, wrapping from SLOTS-1 to 0. Cycles with `in_valid` low do not advance it.
- R7: Lane k on slot s uses the coefficient written at address k*SLOTS + s.
- R8: A write is ignored when, in its cycle, `in_valid` is high or any of the three pipeline stages holds a valid bin. A write in any other cycle replaces the addressed coefficient for all later frames.
- R9: Lane k of `in_data` and `out_data` occupies bits [k*2*DW +: 2*DW], with the real part in the upper DW bits. `cfg_data` holds the coefficient real part in its upper CW bits and the imaginary part in its lower CW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | AW = clog2(LANES*SLOTS) | Coefficient address, lane*SLOTS + slot |
| cfg_data | input | 2*CW | Coefficient {real, imag} |
| in_valid | input | 1 | Input bins valid this cycle |
| in_sof | input | 1 | First cycle of a transform frame |
| in_data | input | LANES*2*DW | Input bins, one {real, imag} per lane |
| out_valid | output | 1 | Output products valid |
| out_data | output | LANES*2*DW | Rounded products, one {real, imag} per lane |

## Verification
The hardest situations to reach are the ones where the coefficient slot sequence and the write lock interact with what is still inside the pipeline. Examples are a write arriving one or two cycles after the last valid bin, a frame-start flag landing mid-frame, and idle gaps inside a frame. The stimulus reaches these by holding the write strobe across the tail of a frame and by restarting and pausing frames deliberately. It then streams a fresh frame whose per-lane data and coefficients are all distinct, so that a wrong slot or a write that should have been refused shows up as a product mismatch. The rounding and clamping corners are reached with hand-computed bin and coefficient pairs that give exact halves and extreme products on one lane.

// File: rtl/fbcb_pkg.sv
// Package: shared default geometry for the frequency-bin coefficient bank.
// Assumes: consumers take these only as parameter defaults.
package fbcb_pkg;
    localparam int DEF_LANES = 8;   // parallel bins per clock
    localparam int DEF_SLOTS = 8;   // bins per lane per frame
    localparam int DEF_DW    = 12;  // data width per real/imag part
    localparam int DEF_CW    = 8;   // coefficient width per part
    localparam int DEF_FRAC  = 7;   // fractional bits of the coefficient
    localparam int PIPE_LAT  = 3;   // register stages from input to output
endpackage

// File: rtl/fbcb_slot_ctr.sv
// Module: per-frame coefficient slot sequencer.
// Produces the slot index for the current valid cycle: zero on frame
// start, otherwise one more than the previous valid cycle, wrapping.
// Assumes: sof is only meaningful together with valid.
module fbcb_slot_ctr #(
    parameter int SLOTS = fbcb_pkg::DEF_SLOTS,
    localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          sof,
    output logic [SW-1:0] slot
);
    localparam logic [SW-1:0] LAST  = SW'(SLOTS - 1);
    localparam logic [SW-1:0] AFTER0 = SW'((SLOTS > 1) ? 1 : 0);

    logic [SW-1:0] nxt;

    // Current slot: a frame start forces slot zero.
    always_comb slot = sof ? '0 : nxt;

    // Advance the stored slot once per valid cycle, wrapping at SLOTS.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nxt <= '0;
        else if (valid)
            nxt <= (slot == LAST) ? '0 : slot + SW'(1);
    end

    // R6: a frame start leaves slot one queued for the next valid cycle
    p_sof_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid && sof |=> nxt == AFTER0);
    // R6: idle cycles do not move the sequence
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(nxt));
    // R6: the last slot is followed by slot zero
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !sof && nxt == LAST |=> nxt == '0);
endmodule

// File: rtl/fbcb_coef_store.sv
// Module: coefficient storage for all lanes.
// One write port (lane*SLOTS+slot addressing) that is locked while the
// bank is busy, and one read per lane at the shared slot index.
// Assumes: busy covers every cycle in which a read result is consumed.
module fbcb_coef_store #(
    parameter int LANES = fbcb_pkg::DEF_LANES,
    parameter int SLOTS = fbcb_pkg::DEF_SLOTS,
    parameter int CW    = fbcb_pkg::DEF_CW,
    localparam int DEPTH = LANES * SLOTS,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic                    busy,
    input  logic [AW-1:0]           addr,
    input  logic [2*CW-1:0]         wdata,
    input  logic [SW-1:0]           slot,
    output logic [LANES*2*CW-1:0]   rdata
);
    logic [2*CW-1:0] mem [DEPTH];

    // Clear on reset; accept a write only while the datapath is empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && !busy && int'(addr) < DEPTH) begin
            mem[addr] <= wdata;
        end
    end

    // Per-lane read at the common slot index.
    for (genvar k = 0; k < LANES; k++) begin : g_rd
        assign rdata[k*2*CW +: 2*CW] = mem[k*SLOTS + int'(slot)];
    end

    // R8: a write during a busy cycle leaves the addressed word unchanged
    p_write_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we && busy |=> mem[$past(addr)] == $past(mem[addr]));
endmodule

// File: rtl/fbcb_cmul_lane.sv
// Module: one lane's complex multiplier with rounding and clamping.
// Stage 1 registers the bin and coefficient, stage 2 the full-precision
// products, stage 3 the rounded and clamped result.
// Assumes: the coefficient has FRAC fractional bits, FRAC >= 1.
module fbcb_cmul_lane #(
    parameter int DW   = fbcb_pkg::DEF_DW,
    parameter int CW   = fbcb_pkg::DEF_CW,
    parameter int FRAC = fbcb_pkg::DEF_FRAC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*DW-1:0]   d_in,
    input  logic [2*CW-1:0]   c_in,
    output logic [2*DW-1:0]   y
);
    localparam int PW = DW + CW + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (DW - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -PW'(1 << (DW - 1));

    logic signed [DW-1:0] dr1, di1;
    logic signed [CW-1:0] cr1, ci1;
    logic signed [PW-1:0] pr2, pi2;
    logic signed [PW-1:0] mr, mi;

    // Round half up then clamp to the DW-bit range.
    function automatic logic [DW-1:0] rnd_sat(input logic signed [PW-1:0] p);
        logic signed [PW-1:0] s;
        s = (p + HALF) >>> FRAC;
        if (s > MAXV)      return MAXV[DW-1:0];
        else if (s < MINV) return MINV[DW-1:0];
        else               return s[DW-1:0];
    endfunction

    // Stage 1: capture the bin and its coefficient.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr1 <= '0; di1 <= '0; cr1 <= '0; ci1 <= '0;
        end else begin
            dr1 <= d_in[2*DW-1:DW];
            di1 <= d_in[DW-1:0];
            cr1 <= c_in[2*CW-1:CW];
            ci1 <= c_in[CW-1:0];
        end
    end

    // Full-precision complex product of the stage-1 operands.
    always_comb begin
        mr = PW'(dr1) * PW'(cr1) - PW'(di1) * PW'(ci1);
        mi = PW'(dr1) * PW'(ci1) + PW'(di1) * PW'(cr1);
    end

    // Stage 2: hold the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr2 <= '0; pi2 <= '0;
        end else begin
            pr2 <= mr;
            pi2 <= mi;
        end
    end

    // Stage 3: rounded and clamped output.
    always_ff @(posedge clk) begin
        if (!rst_n) y <= '0;
        else        y <= {rnd_sat(pr2), rnd_sat(pi2)};
    end

    // R3: a zero coefficient yields a zero result two stages later
    p_zero_coef_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cr1 == '0 && ci1 == '0 |-> ##2 y == '0);
endmodule

// File: rtl/fbin_coef_bank.sv
// Module: frequency-bin coefficient multiplier bank (top).
// Multiplies LANES bins per clock by per-lane, per-slot coefficients,
// with a three-cycle valid-aligned pipeline and a busy-locked write port.
// Assumes: a frame is SLOTS valid cycles beginning with in_sof.
module fbin_coef_bank #(
    parameter int LANES = fbcb_pkg::DEF_LANES,
    parameter int SLOTS = fbcb_pkg::DEF_SLOTS,
    parameter int DW    = fbcb_pkg::DEF_DW,
    parameter int CW    = fbcb_pkg::DEF_CW,
    parameter int FRAC  = fbcb_pkg::DEF_FRAC,
    localparam int AW   = (LANES * SLOTS > 1) ? $clog2(LANES * SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [AW-1:0]           cfg_addr,
    input  logic [2*CW-1:0]         cfg_data,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic [LANES*2*DW-1:0]   in_data,
    output logic                    out_valid,
    output logic [LANES*2*DW-1:0]   out_data
);
    localparam int SW  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int LAT = fbcb_pkg::PIPE_LAT;

    logic [SW-1:0]          slot;
    logic [LANES*2*CW-1:0]  coefs;
    logic [LAT-1:0]         vpipe;
    logic                   busy;

    // The datapath is busy while a bin is entering or in flight.
    always_comb busy = in_valid | (|vpipe);

    // Valid travels beside the data through LAT stages.
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[LAT-2:0], in_valid};
    end

    always_comb out_valid = vpipe[LAT-1];

    fbcb_slot_ctr #(.SLOTS(SLOTS)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (in_valid),
        .sof   (in_sof),
        .slot  (slot)
    );

    fbcb_coef_store #(.LANES(LANES), .SLOTS(SLOTS), .CW(CW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .busy  (busy),
        .addr  (cfg_addr),
        .wdata (cfg_data),
        .slot  (slot),
        .rdata (coefs)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        fbcb_cmul_lane #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_mul (
            .clk   (clk),
            .rst_n (rst_n),
            .d_in  (in_data[k*2*DW +: 2*DW]),
            .c_in  (coefs[k*2*CW +: 2*CW]),
            .y     (out_data[k*2*DW +: 2*DW])
        );
    end

    // R2: every accepted bin emerges exactly three cycles later
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);
    // R2: no valid output without an input three cycles before
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);
endmodule

// File: tb/fbin_coef_bank_test.sv
module fbin_coef_bank_test;
    localparam int LANES = 8, SLOTS = 8, DW = 12, CW = 8, FRAC = 7;
    localparam int AW = 6, DB = LANES * 2 * DW, DEPTH = LANES * SLOTS;

    typedef struct packed {
        logic signed [11:0] dr, di;
        logic signed [7:0]  cr, ci;
        logic signed [11:0] er, ei;
    } vec_t;

    // Lane-0 vectors: bin, coefficient (slot = index), expected result.
    localparam vec_t VT [8] = '{
        '{12'sd100,   12'sd0,    8'sd64,   8'sd0,   12'sd50,    12'sd0},
        '{12'sd1,     12'sd0,    8'sd64,   8'sd0,   12'sd1,     12'sd0},
        '{-12'sd1,    12'sd0,    8'sd64,   8'sd0,   12'sd0,     12'sd0},
        '{12'sd2047,  12'sd2047, 8'sd127, -8'sd128, 12'sd2047, -12'sd16},
        '{-12'sd2048, -12'sd2048, 8'sd127, -8'sd128, -12'sd2048, 12'sd16},
        '{12'sd3,     12'sd5,    8'sd10,   8'sd20, -12'sd1,     12'sd1},
        '{-12'sd300,  12'sd200, -8'sd50,   8'sd30,  12'sd70,   -12'sd148},
        '{12'sd1000, -12'sd1000, 8'sd0,    8'sd0,   12'sd0,     12'sd0}
    };

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0, in_valid = 0, in_sof = 0;
    logic [AW-1:0] cfg_addr = '0;
    logic [2*CW-1:0] cfg_data = '0;
    logic [DB-1:0] in_data = '0;
    logic out_valid;
    logic [DB-1:0] out_data;

    int nchk = 0, nfail = 0, ncyc = 0, slot_m = 0;
    logic [15:0] shadow [DEPTH];
    logic ev [3];
    logic [DB-1:0] ed [3];
    string etag [3];

    always #5 clk = ~clk;

    fbin_coef_bank #(.LANES(LANES), .SLOTS(SLOTS), .DW(DW), .CW(CW), .FRAC(FRAC)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

    function automatic vec_tag(input int i, output string t);
        if (i <= 2) t = "R4"; else if (i <= 4) t = "R5"; else t = "R3";
    endfunction

    function automatic logic [11:0] rsat(input longint p);
        longint s = (p + 64) >>> 7;
        if (s > 2047) s = 2047;
        if (s < -2048) s = -2048;
        return s[11:0];
    endfunction

    function automatic logic [23:0] cmul(input logic [23:0] d, input logic [15:0] c);
        longint dr = longint'($signed(d[23:12])), di = longint'($signed(d[11:0]));
        longint cr = longint'($signed(c[15:8])),  ci = longint'($signed(c[7:0]));
        return {rsat(dr * cr - di * ci), rsat(dr * ci + di * cr)};
    endfunction

    function automatic logic [15:0] cform(input int k, input int s);
        logic [7:0] r = 8'((k * 37 + s * 11) % 200 - 100);
        logic [7:0] i = 8'((k * 53 + s * 29) % 180 - 90);
        return {r, i};
    endfunction

    function automatic logic [DB-1:0] dform(input int n);
        logic [DB-1:0] b;
        for (int k = 0; k < LANES; k++)
            b[k*24 +: 24] = {12'((n * 173 + k * 311) % 4000 - 2000),
                             12'((n * 97 + k * 211) % 3800 - 1900)};
        return b;
    endfunction

    // One cycle: compare outputs, then drive new inputs and predict.
    task automatic tick(input logic v, input logic sof, input logic [DB-1:0] d,
                        input logic we, input int a, input logic [15:0] cd,
                        input string tag);
        logic busy;
        int sl;
        @(negedge clk);
        ncyc++;
        nchk++;
        if (out_valid !== ev[2]) begin
            nfail++;
            $display("FAIL R2 (%s) out_valid got %0b expected %0b", etag[2], out_valid, ev[2]);
        end
        if (ev[2] === 1'b1) begin
            nchk++;
            if (out_data !== ed[2]) begin
                nfail++;
                $display("FAIL %s out_data got %h expected %h", etag[2], out_data, ed[2]);
            end
        end
        busy = v | ev[0] | ev[1] | ev[2];
        ev[2] = ev[1]; ed[2] = ed[1]; etag[2] = etag[1];
        ev[1] = ev[0]; ed[1] = ed[0]; etag[1] = etag[0];
        ev[0] = v; etag[0] = tag; ed[0] = '0;
        in_valid = v; in_sof = sof; in_data = d;
        cfg_we = we; cfg_addr = AW'(a); cfg_data = cd;
        if (v) begin
            sl = sof ? 0 : slot_m;
            for (int k = 0; k < LANES; k++)
                ed[0][k*24 +: 24] = cmul(d[k*24 +: 24], shadow[k*SLOTS + sl]);
            slot_m = (sl == SLOTS - 1) ? 0 : sl + 1;
        end
        if (we && !busy) shadow[a] = cd;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(0, 0, '0, 0, 0, '0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; in_sof = 0; cfg_we = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 3; i++) begin ev[i] = 0; ed[i] = '0; etag[i] = "R1"; end
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        slot_m = 0;
    endtask

    task automatic frame(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(1, i == 0, dform(ncyc), 0, 0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        string t;
        do_reset();
        // R1: quiet output and zero coefficients after reset
        idle(3, "R1");
        frame(SLOTS, "R1");
        idle(3, "R1");
        // R7: load lane0 from the vector table, other lanes from a formula
        for (int k = 0; k < LANES; k++)
            for (int s = 0; s < SLOTS; s++)
                tick(0, 0, '0, 1, k * SLOTS + s,
                     (k == 0) ? {VT[s].cr, VT[s].ci} : cform(k, s), "R7");
        idle(2, "R7");
        // R3/R4/R5: walk the table on lane 0, slot i carries vector i
        for (int i = 0; i < SLOTS; i++) begin
            logic [DB-1:0] d = dform(ncyc);
            d[23:0] = {VT[i].dr, VT[i].di};
            vec_tag(i, t);
            tick(1, i == 0, d, 0, 0, '0, t);
            ed[0][23:0] = {VT[i].er, VT[i].ei};
        end
        idle(3, "R3");
        // R7/R9: per-lane address map and lane packing
        frame(SLOTS, "R9");
        idle(3, "R7");
        // R6: run past the frame length so the slot wraps
        frame(SLOTS + 5, "R6");
        // R6: idle gap mid-frame does not advance the slot
        idle(2, "R6");
        for (int i = 0; i < 3; i++) tick(1, 0, dform(ncyc), 0, 0, '0, "R6");
        // R6: frame start in mid-frame restarts at slot 0
        for (int i = 0; i < 4; i++) tick(1, i == 0, dform(ncyc), 0, 0, '0, "R6");
        idle(3, "R6");
        // R8: writes during input and during pipeline drain are refused
        for (int i = 0; i < SLOTS; i++)
            tick(1, i == 0, dform(ncyc), i == 2, 0, 16'h7f7f, "R8");
        tick(0, 0, '0, 1, 1, 16'h8080, "R8");
        tick(0, 0, '0, 1, 9, 16'h1111, "R8");
        tick(0, 0, '0, 1, 2, 16'h2222, "R8");
        idle(1, "R8");
        frame(SLOTS, "R8");
        idle(3, "R8");
        // R8: a write while idle takes effect on the next frame
        tick(0, 0, '0, 1, 0, 16'h4020, "R8");
        tick(0, 0, '0, 1, 63, 16'hc0f0, "R8");
        frame(SLOTS, "R8");
        idle(3, "R8");
        // R1: reset with data in flight clears output and coefficients
        for (int i = 0; i < 4; i++) tick(1, i == 0, dform(ncyc), 0, 0, '0, "R1");
        do_reset();
        idle(3, "R1");
        frame(SLOTS, "R1");
        idle(4, "R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule